// File: doc/BRIEF.md
# Timebase Timer with Edge Capture

This peripheral runs from the oscillator clock. It has two jobs. First, it raises a timebase event at a fixed interval, and that interval can be set to one of two lengths. Second, on each rising or falling edge of an external pin, it copies the value of a free-running 8-bit up-counter into a holding register.

Software reaches the block through a small register port. The port has an address, a write strobe and a read strobe, and it decodes a control/status byte, the held capture value and a live view of the up-counter. Read data is decoded from the address alone, so a read with no strobe has no side effect. With the strobe, reading the control/status byte clears the timebase flag, and reading the capture register clears the capture flag. One interrupt line combines both flags, and each flag is gated by its own enable.

A capture only happens while the capture flag is clear. This protects an unread value from being overwritten. The capture flag's value after reset has no defined meaning, so it is a parameter, and software clears it with a single read of the capture register before first use.

Top module: `tbtimer_capture`

## Requirements
- R1: After reset, the control/status byte reads 40h (capture flag at bit 6 equals its reset parameter, default 1; all other bits 0). The capture register (address 1) and the counter view (address 2) read 00h.
- R2: With the period-select bit (bit 5) at 0, the timebase flag (bit 3) sets on the 8000th clock edge after the last control/status write (address 0).
- R3: With the period-select bit at 1, the timebase flag sets on the 16000th clock edge after the last control/status write.
- R4: Every control/status write restarts the timebase interval from zero.
- R5: A strobed read of address 0 clears the timebase flag. A write leaves the flag unchanged.
- R6: Only a strobed read of address 1 clears the capture flag. Reading address 0 or writing it leaves the flag unchanged.
- R7: While the capture flag is clear, a rising or falling pin edge sets the flag and loads the counter value into the capture register. This happens on the third clock edge after the pin changes, and the value loaded is the one the counter held after the second edge.
- R8: While the capture flag is set, pin edges change neither the capture register nor the flag.
- R9: When a flag-setting event and that flag's clearing read fall on the same edge, the flag ends up set.
- R10: The irq output is (capture flag AND bit 7) OR (timebase flag AND bit 4).
- R11: The counter view (address 2) rises by exactly one every 4 clocks and wraps from FFh to 00h.
- R12: Bits 2:0 of address 0 read 0 and ignore writes. Address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control/status, 1 capture, 2 counter view |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; triggers the clear-on-read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cap_pin | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Some rules are checked by assertions on every cycle: both flags stay set until their own clearing read, the capture register is stable while its flag is held, the counter only ever advances by one, the gap between timebase events matches the selected period, the reserved bits read 0, and the interrupt stays low when both enables are off. The scenarios are needed for the exact capture latency and for which counter value gets latched. They also cover the two same-edge collisions between a set event and a clearing read, and the restart caused by a control write. A behavioural model checks these against both periods.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_HOLD = 2'd1;
   localparam logic [ADDR_W-1:0] A_LIVE = 2'd2;

   localparam int B_CAP_EN  = 7;
   localparam int B_CAP_FLG = 6;
   localparam int B_LONG    = 5;
   localparam int B_TB_EN   = 4;
   localparam int B_TB_FLG  = 3;

   typedef struct packed {
      logic cap_en;
      logic long_sel;
      logic tb_en;
   } ctrl_t;
endpackage

// File: rtl/tbt_modcount.sv
module tbt_modcount #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         wrap
);
   assign wrap = en && !clr && (count == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)      count <= '0;
      else if (clr)    count <= '0;
      else if (wrap)   count <= '0;
      else if (en)     count <= count + 1'b1;
   end
endmodule

// File: rtl/tbt_edge_sync.sv
module tbt_edge_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic edge_any
);
   logic pipe [0:STAGES];

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= RST_VAL;
            else        pipe[i] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= RST_VAL;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   assign edge_any = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/tbt_flag.sv
module tbt_flag #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RST_VAL;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/tbtimer_capture.sv
module tbtimer_capture
   import tbt_pkg::*;
#(
   parameter int   SHORT_PERIOD = 8000,
   parameter int   LONG_PERIOD  = 16000,
   parameter int   TICK_DIV     = 4,
   parameter int   SYNC_STAGES  = 2,
   parameter logic CAPF_RST     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cap_pin,
   output logic              irq
);
   localparam int TB_W  = $clog2(LONG_PERIOD);
   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (SHORT_PERIOD < 2) begin : g_bad_short
      $error("SHORT_PERIOD must be at least 2");
   end
   if (LONG_PERIOD < SHORT_PERIOD) begin : g_bad_long
      $error("LONG_PERIOD must not be below SHORT_PERIOD");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ctrl_t             ctrl_q;
   logic              wr_ctrl, rd_ctrl, rd_hold;
   logic              tb_ovf, tb_flag, cap_flag, cap_set, pin_edge, tick;
   logic [TB_W-1:0]   tb_count, tb_limit;
   logic [DATA_W-1:0] live_cnt, hold_q, ctrl_view;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign rd_ctrl = bus_rd && (bus_addr == A_CTRL);
   assign rd_hold = bus_rd && (bus_addr == A_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (wr_ctrl) begin
         ctrl_q.cap_en   <= bus_wdata[B_CAP_EN];
         ctrl_q.long_sel <= bus_wdata[B_LONG];
         ctrl_q.tb_en    <= bus_wdata[B_TB_EN];
      end
   end

   // timebase interval
   assign tb_limit = ctrl_q.long_sel ? TB_W'(LONG_PERIOD - 1) : TB_W'(SHORT_PERIOD - 1);

   tbt_modcount #(.W(TB_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .clr(wr_ctrl), .en(1'b1),
      .limit(tb_limit), .count(tb_count), .wrap(tb_ovf)
   );

   // counter prescaler
   if (TICK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      logic [PRE_W-1:0] pre_count;
      tbt_modcount #(.W(PRE_W)) u_pre (
         .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(1'b1),
         .limit(PRE_W'(TICK_DIV - 1)), .count(pre_count), .wrap(tick)
      );
   end

   logic live_wrap;
   tbt_modcount #(.W(DATA_W)) u_live (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(tick),
      .limit({DATA_W{1'b1}}), .count(live_cnt), .wrap(live_wrap)
   );

   // capture path
   tbt_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin), .edge_any(pin_edge)
   );

   assign cap_set = pin_edge && !cap_flag;

   always_ff @(posedge clk) begin
      if (!rst_n)       hold_q <= '0;
      else if (cap_set) hold_q <= live_cnt;
   end

   tbt_flag #(.RST_VAL(CAPF_RST)) u_capf (
      .clk(clk), .rst_n(rst_n), .set(cap_set), .clr(rd_hold), .q(cap_flag)
   );
   tbt_flag #(.RST_VAL(1'b0)) u_tbf (
      .clk(clk), .rst_n(rst_n), .set(tb_ovf), .clr(rd_ctrl), .q(tb_flag)
   );

   // read side
   always_comb begin
      ctrl_view            = '0;
      ctrl_view[B_CAP_EN]  = ctrl_q.cap_en;
      ctrl_view[B_CAP_FLG] = cap_flag;
      ctrl_view[B_LONG]    = ctrl_q.long_sel;
      ctrl_view[B_TB_EN]   = ctrl_q.tb_en;
      ctrl_view[B_TB_FLG]  = tb_flag;
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_view;
         A_HOLD:  bus_rdata = hold_q;
         A_LIVE:  bus_rdata = live_cnt;
         default: bus_rdata = '0;
      endcase
   end

   assign irq = (cap_flag && ctrl_q.cap_en) || (tb_flag && ctrl_q.tb_en);
endmodule

// File: rtl/tbt_chk.sv
module tbt_chk
   import tbt_pkg::*;
#(
   parameter int SHORT_PERIOD = 8000,
   parameter int LONG_PERIOD  = 16000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              cap_flag,
   input logic              tb_flag,
   input logic              tb_ovf,
   input logic              long_sel,
   input logic              cap_en,
   input logic              tb_en,
   input logic [DATA_W-1:0] hold_q,
   input logic [DATA_W-1:0] live_cnt
);
   logic [31:0] gap;
   always_ff @(posedge clk) begin
      if (!rst_n) gap <= '0;
      else if (tb_ovf || (bus_wr && bus_addr == A_CTRL)) gap <= '0;
      else gap <= gap + 1;
   end

   AST_TB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tb_ovf |-> (gap == (long_sel ? LONG_PERIOD - 1 : SHORT_PERIOD - 1))); // R2

   AST_TBF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_flag && !(bus_rd && bus_addr == A_CTRL)) |=> tb_flag); // R5

   AST_CAPF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !(bus_rd && bus_addr == A_HOLD)) |=> cap_flag); // R6

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cap_flag) |-> $stable(hold_q)); // R8

   AST_LIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt != $past(live_cnt)) |-> (live_cnt == DATA_W'($past(live_cnt) + 1'b1))); // R11

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en && !tb_en) |-> !irq); // R10

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_CTRL) |-> (bus_rdata[2:0] == 3'b000)); // R12
endmodule

bind tbtimer_capture tbt_chk #(
   .SHORT_PERIOD(SHORT_PERIOD), .LONG_PERIOD(LONG_PERIOD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
   .cap_flag(cap_flag), .tb_flag(tb_flag), .tb_ovf(tb_ovf),
   .long_sel(ctrl_q.long_sel), .cap_en(ctrl_q.cap_en), .tb_en(ctrl_q.tb_en),
   .hold_q(hold_q), .live_cnt(live_cnt)
);

// File: tb/tbtimer_capture_tb.sv
module tbtimer_capture_tb;
   localparam int SHORT = 8000;
   localparam int LONG  = 16000;
   localparam int DIV   = 4;

   logic       clk = 0;
   logic       rst_n = 0;
   logic [1:0] bus_addr = 0;
   logic       bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic       cap_pin = 0;
   logic       irq;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   tbtimer_capture u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_pin(cap_pin), .irq(irq)
   );

   always #5 clk = ~clk;

   // behavioural reference model
   int m_tb, m_pre, m_cnt, m_cap;
   bit m_tbf, m_capf, m_cie, m_sel, m_tie, p1, p2, p3;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tb = 0; m_pre = 0; m_cnt = 0; m_cap = 0;
         m_tbf = 0; m_capf = 1; m_cie = 0; m_sel = 0; m_tie = 0;
         p1 = 0; p2 = 0; p3 = 0;
      end else begin
         bit ovf, cset, wrc, rdc, rdh;
         int per;
         wrc = bus_wr && bus_addr == 0;
         rdc = bus_rd && bus_addr == 0;
         rdh = bus_rd && bus_addr == 1;
         per = m_sel ? LONG : SHORT;
         ovf = 0;
         if (wrc) m_tb = 0;
         else if (m_tb == per - 1) begin m_tb = 0; ovf = 1; end
         else m_tb = m_tb + 1;
         cset = (p2 != p3) && !m_capf;
         if (cset) m_cap = m_cnt;
         if (m_pre == DIV - 1) begin m_pre = 0; m_cnt = (m_cnt + 1) % 256; end
         else m_pre = m_pre + 1;
         m_tbf  = ovf  ? 1 : (rdc ? 0 : m_tbf);
         m_capf = cset ? 1 : (rdh ? 0 : m_capf);
         if (wrc) begin m_cie = bus_wdata[7]; m_sel = bus_wdata[5]; m_tie = bus_wdata[4]; end
         p3 = p2; p2 = p1; p1 = cap_pin;
      end
   end

   function automatic int model_rd(input logic [1:0] a);
      case (a)
         2'd0: return {m_cie, m_capf, m_sel, m_tie, m_tbf, 3'b000};
         2'd1: return m_cap;
         2'd2: return m_cnt;
         default: return 0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ei;
         ei = (m_capf && m_cie) || (m_tbf && m_tie);
         checks++;
         if (irq !== ei) begin
            fails++;
            $display("FAIL R10 model irq: got %0b exp %0b at cycle %0d", irq, ei, cyc);
         end
         checks++;
         if (int'(bus_rdata) !== model_rd(bus_addr)) begin
            fails++;
            $display("FAIL R1/R12 model rdata addr %0d: got %02h exp %02h", bus_addr, bus_rdata, model_rd(bus_addr));
         end
      end
   end

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h exp %0h", req, got, exp);
      end
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); #1;
      bus_wr = 0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_rd = 1; #1; d = bus_rdata;
      @(negedge clk); #1;
      bus_rd = 0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // toggles the pin and checks latency and latched value
   task automatic do_capture(input string req);
      logic [7:0] d, expv;
      cap_pin = ~cap_pin;
      wait_cyc(2);
      peek(2, expv);
      peek(0, d); check({req, " flag still clear after two edges"}, d[6], 0);
      wait_cyc(1);
      peek(0, d); check({req, " flag set on third edge"}, d[6], 1);
      peek(1, d); check({req, " latched value"}, d, expv);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, c0, held;
      wait_cyc(3);
      rst_n = 1;
      #1;
      // R1 reset state
      peek(0, d); check("R1 control reset", d, 8'h40);
      peek(1, d); check("R1 capture reset", d, 0);
      peek(2, d); check("R1 counter reset", d, 0);

      rd_reg(1, d);
      peek(0, d); check("R6 flag cleared by capture read", d[6], 0);

      // R2 short period
      wr_reg(0, 8'h00);
      wait_cyc(SHORT - 1);
      peek(0, d); check("R2 no flag before 8000", d[3], 0);
      wait_cyc(1);
      peek(0, d); check("R2 flag at 8000", d[3], 1);
      check("R10 irq masked", irq, 0);

      wr_reg(0, 8'h10);
      peek(0, d); check("R5 write leaves flag", d[3], 1);
      check("R10 irq from timebase", irq, 1);
      rd_reg(0, d);
      peek(0, d); check("R5 read clears flag", d[3], 0);
      check("R10 irq drops", irq, 0);

      // R4 restart
      wr_reg(0, 8'h00);
      wait_cyc(5000);
      wr_reg(0, 8'h00);
      wait_cyc(SHORT - 1);
      peek(0, d); check("R4 restarted, no flag yet", d[3], 0);
      wait_cyc(1);
      peek(0, d); check("R4 flag after restart", d[3], 1);
      rd_reg(0, d);

      // R3 long period
      wr_reg(0, 8'h20);
      wait_cyc(LONG - 1);
      peek(0, d); check("R3 no flag before 16000", d[3], 0);
      wait_cyc(1);
      peek(0, d); check("R3 flag at 16000", d[3], 1);
      rd_reg(0, d);

      // R9 timebase set beats read
      wr_reg(0, 8'h00);
      wait_cyc(SHORT - 2);
      rd_reg(0, d);
      peek(0, d); check("R9 timebase set wins", d[3], 1);
      rd_reg(0, d);

      // R7 rising capture, R10 capture irq
      wr_reg(0, 8'h80);
      do_capture("R7 rising");
      check("R10 irq from capture", irq, 1);
      peek(1, held);

      // R8 blocked edge
      cap_pin = ~cap_pin;
      wait_cyc(6);
      peek(1, d); check("R8 value unchanged", d, held);
      peek(0, d); check("R8 flag still set", d[6], 1);

      // R6 only capture read clears
      rd_reg(0, d);
      peek(0, d); check("R6 control read keeps flag", d[6], 1);
      wr_reg(0, 8'h80);
      peek(0, d); check("R6 write keeps flag", d[6], 1);
      rd_reg(1, d);
      peek(0, d); check("R6 capture read clears", d[6], 0);
      check("R10 irq low after clear", irq, 0);

      wait_cyc(3);
      cap_pin = 1; wait_cyc(1); cap_pin = 0;
      wait_cyc(4);
      rd_reg(1, d);
      wait_cyc(2);
      do_capture("R7 second");
      rd_reg(1, d);
      wait_cyc(2);
      check("R7 pin high before falling test", cap_pin, 1);
      do_capture("R7 falling");
      rd_reg(1, d);

      // R9 capture set beats read
      cap_pin = ~cap_pin;
      wait_cyc(1);
      rd_reg(1, d);
      peek(0, d); check("R9 capture set wins", d[6], 1);
      rd_reg(1, d);

      // R11 counter step and wrap
      peek(2, c0);
      wait_cyc(DIV);
      peek(2, d); check("R11 one step per period", d, 8'(c0 + 1));
      for (int i = 0; i < 300 && d != 8'hFF; i++) begin
         wait_cyc(DIV);
         peek(2, d);
      end
      check("R11 reached FF", d, 8'hFF);
      wait_cyc(DIV);
      peek(2, d); check("R11 wraps to 00", d, 0);

      // R12 reserved bits
      wr_reg(0, 8'hFF);
      peek(0, d); check("R12 reserved bits zero", d[2:0], 0);
      peek(3, d); check("R12 address 3 reads zero", d, 0);

      wait_cyc(2);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule